// File: doc/BRIEF.md
# Fast-bus to peripheral-bus bridge

This block sits as a slave on a pipelined high-speed bus and acts as the sole master of a simple peripheral bus. The fast side presents the address and control of a transfer in one cycle and the write data in the cycle after. The bridge takes each single read or write and replays it on the peripheral side as a one-cycle setup phase followed by a one-cycle enable phase. While the setup phase runs it holds the fast bus with ready low. In the enable phase it raises ready again and passes the peripheral's read data straight back.

Address and control are latched when a transfer is taken, so they stay constant across both peripheral phases. A four-bit field of the latched address picks one of up to sixteen peripheral selects, one-hot. An index beyond the configured peripheral count selects nothing and reads back zero. Every fast-side transfer is answered OKAY. The peripheral side has no wait states, no bursts and no response signal.

Top module: `fastbus_periph_bridge`

## Requirements
- R1: During and right after reset no peripheral select and no enable are high, fast ready out is high and the response is 00.
- R2: A transfer is taken at a clock edge where fast select is high, the transfer type is NONSEQ (10) or SEQ (11) and the bus ready input is high. In the next cycle (setup) exactly the decoded select is high, enable is low and fast ready out is low.
- R3: A type of IDLE (00) or BUSY (01), a low fast select or a low bus ready input at the edge starts no peripheral access. In the following cycle all selects and enable stay low and ready out stays high.
- R4: Setup lasts exactly one cycle. It is followed by exactly one enable cycle, in which the select stays high, enable is high and fast ready out is high.
- R5: The peripheral address equals the fast address taken for the access. Address, write flag, selects and write data do not change from setup to enable.
- R6: For a write, the peripheral write data in the enable cycle equals the fast write data presented in the cycle after the address phase.
- R7: For a read to a mapped index, fast read data in the enable cycle equals the peripheral read data.
- R8: The select index is address bits [SEL_LSB+3:SEL_LSB]. Index k below NUM_PERIPH raises only select bit k. An index of NUM_PERIPH or more raises no select and returns read data 0.
- R9: A transfer taken at the edge that ends an enable cycle goes straight to a new setup cycle. Without one, the bridge returns to idle.
- R10: The fast response is 00 (OKAY) in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both buses |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_sel | input | 1 | Fast-side slave select |
| fs_trans | input | 2 | Fast-side transfer type |
| fs_addr | input | ADDR_W | Fast-side address (address phase) |
| fs_write | input | 1 | Fast-side write flag (address phase) |
| fs_wdata | input | DATA_W | Fast-side write data (data phase) |
| fs_ready_in | input | 1 | Combined fast-bus ready seen by all slaves |
| fs_ready_out | output | 1 | Ready driven by the bridge |
| fs_resp | output | 2 | Transfer response, always OKAY |
| fs_rdata | output | DATA_W | Read data to the fast side |
| pb_addr | output | ADDR_W | Latched peripheral address |
| pb_sel | output | NUM_PERIPH | One-hot peripheral selects |
| pb_en | output | 1 | Peripheral enable-phase strobe |
| pb_write | output | 1 | Latched peripheral write flag |
| pb_wdata | output | DATA_W | Peripheral write data |
| pb_rdata | input | DATA_W | Read data from the selected peripheral |

## Verification
The bench builds the bridge with NUM_PERIPH set to 12 and SEL_LSB set to 12. With that count, address indices 12 to 15 are unmapped, so the no-select and zero-read-back path can be reached with ordinary addresses next to mapped ones. The bench drives the combined ready input apart from the bridge's own ready, which lets it show a transfer being turned away when another slave holds the bus. Back-to-back transfers, gaps, and the IDLE and BUSY types are mixed so that both exits from the enable phase are taken.

// File: rtl/pb_bridge_pkg.sv
package pb_bridge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_SETUP  = 2'b01,
    PH_ENABLE = 2'b10
  } phase_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // Transfer types that carry a real access
  function automatic logic is_real_transfer(input logic [1:0] tr);
    return (tr == TR_NONSEQ) || (tr == TR_SEQ);
  endfunction

  // Next peripheral phase given the current one and a newly taken transfer
  function automatic phase_e next_phase(input phase_e cur, input logic take);
    if (cur == PH_SETUP) return PH_ENABLE;
    return take ? PH_SETUP : PH_IDLE;
  endfunction

endpackage

// File: rtl/pbb_request_latch.sv
module pbb_request_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              write_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              write_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
    end else if (take) begin
      addr_q  <= addr_in;
      write_q <= write_in;
    end
  end

endmodule

// File: rtl/pbb_phase_ctrl.sv
module pbb_phase_ctrl
  import pb_bridge_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  output phase_e phase_q,
  output logic   in_setup,
  output logic   in_enable
);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= next_phase(phase_q, take);
  end

  assign in_setup  = (phase_q == PH_SETUP);
  assign in_enable = (phase_q == PH_ENABLE);

endmodule

// File: rtl/pbb_wdata_hold.sv
module pbb_wdata_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_setup,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [DATA_W-1:0] wdata_out
);

  logic [DATA_W-1:0] wdata_q;

  // Data phase coincides with setup: pass through, then hold for enable
  always_ff @(posedge clk) begin
    if (!rst_n)        wdata_q <= '0;
    else if (in_setup) wdata_q <= wdata_in;
  end

  assign wdata_out = in_setup ? wdata_in : wdata_q;

endmodule

// File: rtl/pbb_select_decode.sv
module pbb_select_decode #(
  parameter int NUM_PERIPH = 16,
  parameter int SEL_W      = 4
) (
  input  logic [SEL_W-1:0]      index,
  input  logic                  active,
  output logic [NUM_PERIPH-1:0] sel,
  output logic                  mapped
);

  assign mapped = ({1'b0, index} < (SEL_W+1)'(NUM_PERIPH));

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_sel
    assign sel[g] = active && (index == SEL_W'(g));
  end

endmodule

// File: rtl/fastbus_periph_bridge.sv
module fastbus_periph_bridge
  import pb_bridge_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_PERIPH = 16,
  parameter int SEL_LSB    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fs_sel,
  input  logic [1:0]            fs_trans,
  input  logic [ADDR_W-1:0]     fs_addr,
  input  logic                  fs_write,
  input  logic [DATA_W-1:0]     fs_wdata,
  input  logic                  fs_ready_in,
  output logic                  fs_ready_out,
  output logic [1:0]            fs_resp,
  output logic [DATA_W-1:0]     fs_rdata,
  output logic [ADDR_W-1:0]     pb_addr,
  output logic [NUM_PERIPH-1:0] pb_sel,
  output logic                  pb_en,
  output logic                  pb_write,
  output logic [DATA_W-1:0]     pb_wdata,
  input  logic [DATA_W-1:0]     pb_rdata
);

  localparam int SEL_W = 4;

  phase_e            phase_q;
  logic              in_setup;
  logic              in_enable;
  logic              take;
  logic              write_q;
  logic              mapped;
  logic [ADDR_W-1:0] addr_q;

  // Named event: a fast-side transfer is accepted at this edge
  assign take = fs_sel && is_real_transfer(fs_trans) && fs_ready_in && !in_setup;

  pbb_phase_ctrl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .phase_q   (phase_q),
    .in_setup  (in_setup),
    .in_enable (in_enable)
  );

  pbb_request_latch #(.ADDR_W(ADDR_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .addr_in  (fs_addr),
    .write_in (fs_write),
    .addr_q   (addr_q),
    .write_q  (write_q)
  );

  pbb_wdata_hold #(.DATA_W(DATA_W)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_setup  (in_setup),
    .wdata_in  (fs_wdata),
    .wdata_out (pb_wdata)
  );

  pbb_select_decode #(.NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)) u_dec (
    .index  (addr_q[SEL_LSB +: SEL_W]),
    .active (in_setup || in_enable),
    .sel    (pb_sel),
    .mapped (mapped)
  );

  assign pb_addr      = addr_q;
  assign pb_write     = write_q;
  assign pb_en        = in_enable;
  assign fs_ready_out = !in_setup;
  assign fs_resp      = RESP_OKAY;
  assign fs_rdata     = (in_enable && !write_q && mapped) ? pb_rdata : '0;

endmodule

// File: rtl/pbb_checker.sv
module pbb_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_PERIPH = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  take,
  input logic                  fs_ready_out,
  input logic [ADDR_W-1:0]     pb_addr,
  input logic [NUM_PERIPH-1:0] pb_sel,
  input logic                  pb_en,
  input logic                  pb_write,
  input logic [DATA_W-1:0]     pb_wdata
);

  a_r2_take_starts_setup: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!pb_en && !fs_ready_out));

  a_r3_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!pb_en && fs_ready_out) |-> (pb_sel == '0));

  a_r4_setup_then_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_ready_out) |=> (pb_en && fs_ready_out));

  a_r4_enable_single: assert property (@(posedge clk) disable iff (!rst_n)
    pb_en |=> !pb_en);

  a_r5_stable_into_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pb_en |-> ($stable(pb_addr) && $stable(pb_write) && $stable(pb_sel) && $stable(pb_wdata)));

  a_r8_select_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pb_sel));

  a_r9_enable_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pb_en) |-> $past(!fs_ready_out));

endmodule

bind fastbus_periph_bridge pbb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PERIPH(NUM_PERIPH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .take         (take),
  .fs_ready_out (fs_ready_out),
  .pb_addr      (pb_addr),
  .pb_sel       (pb_sel),
  .pb_en        (pb_en),
  .pb_write     (pb_write),
  .pb_wdata     (pb_wdata)
);

// File: tb/fastbus_periph_bridge_tb_top.sv
module fastbus_periph_bridge_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NP = 12;
  localparam int SL = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fs_sel = 1'b0;
  logic [1:0]    fs_trans = 2'b00;
  logic [AW-1:0] fs_addr = '0;
  logic          fs_write = 1'b0;
  logic [DW-1:0] fs_wdata = '0;
  logic          stall_other = 1'b0;
  logic          fs_ready_in;
  logic          fs_ready_out;
  logic [1:0]    fs_resp;
  logic [DW-1:0] fs_rdata;
  logic [AW-1:0] pb_addr;
  logic [NP-1:0] pb_sel;
  logic          pb_en;
  logic          pb_write;
  logic [DW-1:0] pb_wdata;
  logic [DW-1:0] pb_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign fs_ready_in = fs_ready_out && !stall_other;
  assign pb_rdata    = {~pb_addr[15:0], pb_addr[15:0]};

  fastbus_periph_bridge #(.ADDR_W(AW), .DATA_W(DW), .NUM_PERIPH(NP), .SEL_LSB(SL)) dut_i (
    .clk(clk), .rst_n(rst_n), .fs_sel(fs_sel), .fs_trans(fs_trans), .fs_addr(fs_addr),
    .fs_write(fs_write), .fs_wdata(fs_wdata), .fs_ready_in(fs_ready_in),
    .fs_ready_out(fs_ready_out), .fs_resp(fs_resp), .fs_rdata(fs_rdata),
    .pb_addr(pb_addr), .pb_sel(pb_sel), .pb_en(pb_en), .pb_write(pb_write),
    .pb_wdata(pb_wdata), .pb_rdata(pb_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model: 0 idle, 1 setup, 2 enable
  int            m_phase = 0;
  int            m_prev = 0;
  logic [AW-1:0] m_addr = '0;
  logic          m_wr = 1'b0;
  logic [DW-1:0] exp_wd[$];

  always @(posedge clk) begin
    m_prev = m_phase;
    if (!rst_n) m_phase = 0;
    else if (m_phase == 1) m_phase = 2;
    else if (fs_sel && fs_trans >= 2'b10 && fs_ready_in) begin
      m_phase = 1;
      m_addr  = fs_addr;
      m_wr    = fs_write;
    end else m_phase = 0;
  end

  always @(negedge clk) begin
    int            idx;
    logic [NP-1:0] esel;
    logic [DW-1:0] wd;
    string         lab;
    idx  = int'(m_addr[SL +: 4]);
    esel = '0;
    if (m_phase != 0 && idx < NP) esel[idx] = 1'b1;
    if (!rst_n) lab = "R1";
    else if (m_phase == 0) lab = "R3";
    else if (m_phase == 1) lab = (m_prev == 2) ? "R9" : "R2";
    else lab = "R4";
    check({lab, " sel"}, 64'(pb_sel), 64'(esel));
    check({lab, " enable"}, 64'(pb_en), 64'(m_phase == 2));
    check({lab, " ready"}, 64'(fs_ready_out), 64'(m_phase != 1));
    check("R10 resp", 64'(fs_resp), 64'(2'b00));
    if (m_phase != 0) begin
      check("R5 addr", 64'(pb_addr), 64'(m_addr));
      check("R5 write flag", 64'(pb_write), 64'(m_wr));
      if (idx >= NP) check("R8 unmapped sel", 64'(pb_sel), 64'(0));
    end
    if (m_phase == 2) begin
      if (exp_wd.size() == 0) check("R6 queue", 64'(0), 64'(1));
      else begin
        wd = exp_wd.pop_front();
        if (m_wr) check("R6 wdata", 64'(pb_wdata), 64'(wd));
        else if (idx < NP) check("R7 rdata", 64'(fs_rdata), 64'({~m_addr[15:0], m_addr[15:0]}));
        else check("R8 unmapped rdata", 64'(fs_rdata), 64'(0));
      end
    end
  end

  logic [DW-1:0] last_wd = '0;

  task automatic idle_cycle();
    @(negedge clk); #1;
    fs_sel = 1'b0; fs_trans = 2'b00; fs_wdata = last_wd; stall_other = 1'b0;
    @(posedge clk);
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                      input logic [1:0] tr, input logic sl, input logic stl);
    @(negedge clk); #1;
    fs_sel = sl; fs_trans = tr; fs_addr = a; fs_write = wr;
    fs_wdata = last_wd; stall_other = stl;
    if (stl || !sl || tr < 2'b10) @(posedge clk);
    else begin
      while (!fs_ready_in) begin @(negedge clk); #1; end
      @(posedge clk);
      exp_wd.push_back(wd);
      last_wd = wd;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle_cycle(); idle_cycle();
    // R2 R6 write then back-to-back read (R9, R7)
    xfer(32'h0000_3010, 1'b1, 32'h1111_2222, 2'b10, 1'b1, 1'b0);
    xfer(32'h0000_5020, 1'b0, 32'h0,         2'b11, 1'b1, 1'b0);
    idle_cycle(); idle_cycle();
    xfer(32'h0000_B004, 1'b0, 32'h0,         2'b10, 1'b1, 1'b0);
    xfer(32'h0000_0008, 1'b1, 32'hDEAD_BEEF, 2'b11, 1'b1, 1'b0);
    // R3 ignored stimuli
    xfer(32'h0000_2000, 1'b1, 32'h5, 2'b00, 1'b1, 1'b0);
    xfer(32'h0000_2000, 1'b1, 32'h6, 2'b01, 1'b1, 1'b0);
    xfer(32'h0000_2000, 1'b1, 32'h7, 2'b10, 1'b0, 1'b0);
    xfer(32'h0000_2000, 1'b1, 32'h8, 2'b10, 1'b1, 1'b1);
    idle_cycle();
    // R8 unmapped indices, then mapped read right after
    xfer(32'h0000_D000, 1'b0, 32'h0,         2'b10, 1'b1, 1'b0);
    xfer(32'h0000_F00C, 1'b1, 32'hA5A5_5A5A, 2'b10, 1'b1, 1'b0);
    xfer(32'h0000_7ABC, 1'b0, 32'h0,         2'b10, 1'b1, 1'b0);
    xfer(32'h0000_1004, 1'b1, 32'h0BAD_F00D, 2'b10, 1'b1, 1'b0);
    idle_cycle(); idle_cycle(); idle_cycle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule